// File: doc/BRIEF.md
# Eight-Channel Byte-Copy DMA Engine

This block copies bytes between a 24-bit memory space, addressed as an 8-bit bank over a 16-bit offset, and a 256-register peripheral page at 0x0021xx. Each of the eight channels has its own small register set. Software writes a control byte, a peripheral register index, a 16-bit memory offset, a bank and a 16-bit byte count for a channel, then pulses a start input with a mask of channels. The engine runs the selected channels one after another, lowest number first. Each channel runs until its count is exhausted, and `busy_o` stays high until the last selected channel has finished.

Every byte costs two accesses on a single request/ready bus port: a read from the source side, then a write of the same byte to the destination side. On the peripheral side the register index is offset by a small repeating pattern chosen by the channel's mode. This lets one channel feed a pair or a quad of neighbouring registers. The channel's offset and count registers are updated in place as bytes move, so a later run continues from where the last one stopped.

Top module: `dma_engine`

## Requirements
- R1: While and after reset, with no start issued, `busy_o` and `bus_req_o` are low.
- R2: A configuration write selects the channel with `cfg_addr_i[6:4]` and the register with `cfg_addr_i[3:0]`: 0 control, 1 peripheral index, 2 offset low, 3 offset high, 4 bank, 5 count low, 6 count high. Control bit 7 is direction, bit 4 is decrement, bit 3 is fixed and bits 2:0 are the mode. Bits 6 and 5 have no effect.
- R3: Each byte is one read followed by one write, and the written data equals the data just read. The peripheral address is {16'h0021, index + offset}, with the low byte summed modulo 256.
- R4: The mode sets the peripheral offset pattern: 0 gives {0}; 1 gives {0,1}; 2 and 6 give {0,0}; 3 and 7 give {0,0,1,1}; 4 gives {0,1,2,3}; 5 gives {0,1,0,1}.
- R5: Every channel run begins at the first pattern entry. The pattern repeats while the count is non-zero, and the run stops after the byte that brings the count to zero, even partway through a pattern.
- R6: After each byte the 16-bit memory offset steps by +1, or by -1 when decrement is set, or stays put when fixed is set. The offset wraps within 16 bits and the bank never changes.
- R7: A count programmed as zero moves 65536 bytes.
- R8: With direction 0, reads go to memory and writes to the peripheral page. With direction 1 the two are swapped.
- R9: Starting with a mask runs the masked channels in ascending order. `busy_o` rises on the start edge and falls once the last write completes. A zero mask does nothing.
- R10: While `busy_o` is high, start pulses and configuration writes are ignored.
- R11: A request whose `bus_ready_i` is low keeps its address, direction and write data unchanged in the next cycle, and at most one access completes per clock.
- R12: A channel keeps its advanced offset and its zero count after a run. Re-running it after rewriting only the count continues from the advanced offset with the same index and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Channel [6:4] and register [3:0] select |
| cfg_wdata_i | input | 8 | Configuration write data |
| start_i | input | 1 | Start pulse |
| start_mask_i | input | 8 | Channels to run on start |
| busy_o | output | 1 | High while any selected channel remains |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 24 | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid with ready |
| bus_ready_i | input | 1 | Access accepted this cycle |

## Verification
The hardest states to reach are the wrap at the ends of the 16-bit offset, a run that stops partway through a four-entry pattern, and configuration or start activity arriving while a run is in progress. The stimulus places offsets one or two steps from 0x0000 and 0xFFFF, uses counts that are not multiples of the pattern length, and issues writes and a start pulse while a twenty-byte run is stalled by a random ready. The 65536-byte case is run with ready held high, so it finishes within the cycle budget while every access is still compared against the model.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [3:0] {
    REG_CTRL   = 4'd0,
    REG_PIDX   = 4'd1,
    REG_OFS_LO = 4'd2,
    REG_OFS_HI = 4'd3,
    REG_BANK   = 4'd4,
    REG_CNT_LO = 4'd5,
    REG_CNT_HI = 4'd6
  } reg_sel_e;

  typedef struct packed {
    logic       dir;
    logic       dec;
    logic       fix;
    logic [2:0] mode;
  } ctrl_t;

  function automatic logic [2:0] pat_len(logic [2:0] m);
    case (m)
      3'd0:                 return 3'd1;
      3'd1, 3'd2, 3'd6:     return 3'd2;
      default:              return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] pat_off(logic [2:0] m, logic [1:0] p);
    case (m)
      3'd1, 3'd5: return {1'b0, p[0]};
      3'd3, 3'd7: return {1'b0, p[1]};
      3'd4:       return p;
      default:    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_eng_chan_regs.sv
module dma_eng_chan_regs
  import dma_eng_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_reg_i,
  input  logic [7:0]    wr_data_i,
  input  logic          upd_i,
  input  logic [AW-1:0] upd_addr_i,
  input  logic [CW-1:0] upd_cnt_i,
  output ctrl_t         ctrl_o,
  output logic [PW-1:0] pidx_o,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] bank_o,
  output logic [CW-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      pidx_o <= '0;
      addr_o <= '0;
      bank_o <= '0;
      cnt_o  <= '0;
    end else if (wr_en_i) begin
      case (wr_reg_i)
        REG_CTRL:   ctrl_o <= '{dir: wr_data_i[7], dec: wr_data_i[4],
                                fix: wr_data_i[3], mode: wr_data_i[2:0]};
        REG_PIDX:   pidx_o <= wr_data_i[PW-1:0];
        REG_OFS_LO: addr_o[7:0] <= wr_data_i;
        REG_OFS_HI: addr_o[AW-1:8] <= wr_data_i[AW-9:0];
        REG_BANK:   bank_o <= wr_data_i[BW-1:0];
        REG_CNT_LO: cnt_o[7:0] <= wr_data_i;
        REG_CNT_HI: cnt_o[CW-1:8] <= wr_data_i[CW-9:0];
        default: ;
      endcase
    end else if (upd_i) begin
      addr_o <= upd_addr_i;
      cnt_o  <= upd_cnt_i;
    end
  end

  // R6
  bank_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !wr_en_i |=> bank_o == $past(bank_o));

endmodule

// File: rtl/dma_eng_arb.sv
module dma_eng_arb #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  output logic [IW-1:0] grant_o,
  output logic          any_o
);

  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) grant_o = IW'(i);
    end
  end

  assign any_o = |pend_i;

  // R9
  lowest_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> pend_i[grant_o] && ((pend_i & ((N'(1) << grant_o) - N'(1))) == '0));

endmodule

// File: rtl/dma_eng_xfer.sv
module dma_eng_xfer
  import dma_eng_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N),
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned PW = 8,
  parameter logic [BW+AW-PW-1:0] PERI_PAGE = 'h0021,
  localparam int unsigned XW = BW + AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  start_mask_i,
  output logic          busy_o,
  output logic [N-1:0]  pend_o,
  input  logic [IW-1:0] grant_i,
  input  logic          any_i,
  output logic [IW-1:0] cur_ch_o,
  input  ctrl_t         ctrl_i,
  input  logic [PW-1:0] pidx_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bank_i,
  input  logic [CW-1:0] cnt_i,
  output logic          upd_o,
  output logic [AW-1:0] upd_addr_o,
  output logic [CW-1:0] upd_cnt_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [XW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic [7:0]    bus_rdata_i,
  input  logic          bus_ready_i
);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  st_e           st_q;
  logic [N-1:0]  pend_q;
  logic [IW-1:0] cur_q;
  logic [1:0]    ptr_q, ptr_nxt;
  logic [7:0]    data_q;
  logic [XW-1:0] mem_addr, per_addr;
  logic [1:0]    off;
  logic          last_byte;

  assign busy_o   = (pend_q != '0) || (st_q != ST_IDLE);
  assign pend_o   = pend_q;
  assign cur_ch_o = cur_q;

  assign off       = pat_off(ctrl_i.mode, ptr_q);
  assign mem_addr  = {bank_i, addr_i};
  assign per_addr  = {PERI_PAGE, pidx_i + PW'(off)};
  assign ptr_nxt   = (({1'b0, ptr_q} + 3'd1) == pat_len(ctrl_i.mode)) ? 2'd0 : ptr_q + 2'd1;
  assign last_byte = (cnt_i == CW'(1));

  assign bus_req_o   = (st_q != ST_IDLE);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_addr_o  = ((st_q == ST_WR) != ctrl_i.dir) ? per_addr : mem_addr;
  assign bus_wdata_o = data_q;

  // count zero wraps to all ones: 0 means a full 2^CW run
  assign upd_o      = (st_q == ST_WR) && bus_ready_i;
  assign upd_cnt_o  = cnt_i - CW'(1);
  assign upd_addr_o = ctrl_i.fix ? addr_i : (ctrl_i.dec ? addr_i - AW'(1) : addr_i + AW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      cur_q  <= '0;
      ptr_q  <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i && pend_q == '0) begin
            pend_q <= start_mask_i;
          end else if (any_i) begin
            cur_q <= grant_i;
            ptr_q <= '0;
            st_q  <= ST_RD;
          end
        end
        ST_RD: begin
          if (bus_ready_i) begin
            data_q <= bus_rdata_i;
            st_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (bus_ready_i) begin
            ptr_q <= ptr_nxt;
            if (last_byte) begin
              pend_q[cur_q] <= 1'b0;
              st_q          <= ST_IDLE;
            end else begin
              st_q <= ST_RD;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o) &&
                                  $stable(bus_we_o) && $stable(bus_wdata_o));

  // R10
  no_new_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (pend_q & ~$past(pend_q)) == '0);

  // R7
  zero_cnt_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR) && bus_ready_i && (cnt_i == '0) |=> st_q == ST_RD);

  // R3
  rd_before_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_we_o) |-> $past(bus_req_o) && !$past(bus_we_o) && $past(bus_ready_i));

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_eng_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  parameter int unsigned AW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned BW   = 8,
  parameter int unsigned PW   = 8,
  parameter logic [BW+AW-PW-1:0] PERI_PAGE = 'h0021,
  localparam int unsigned IW = $clog2(N_CH),
  localparam int unsigned XW = BW + AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [IW+3:0]   cfg_addr_i,
  input  logic [7:0]      cfg_wdata_i,
  input  logic            start_i,
  input  logic [N_CH-1:0] start_mask_i,
  output logic            busy_o,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic [XW-1:0]   bus_addr_o,
  output logic [7:0]      bus_wdata_o,
  input  logic [7:0]      bus_rdata_i,
  input  logic            bus_ready_i
);

  ctrl_t         ctrl_a [N_CH];
  logic [PW-1:0] pidx_a [N_CH];
  logic [AW-1:0] addr_a [N_CH];
  logic [BW-1:0] bank_a [N_CH];
  logic [CW-1:0] cnt_a  [N_CH];

  logic [N_CH-1:0] pend;
  logic [IW-1:0]   grant, cur_ch;
  logic            any, upd;
  logic [AW-1:0]   upd_addr;
  logic [CW-1:0]   upd_cnt;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dma_eng_chan_regs #(.AW(AW), .CW(CW), .BW(BW), .PW(PW)) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (cfg_we_i && !busy_o && (cfg_addr_i[IW+3:4] == IW'(g))),
      .wr_reg_i  (cfg_addr_i[3:0]),
      .wr_data_i (cfg_wdata_i),
      .upd_i     (upd && (cur_ch == IW'(g))),
      .upd_addr_i(upd_addr),
      .upd_cnt_i (upd_cnt),
      .ctrl_o    (ctrl_a[g]),
      .pidx_o    (pidx_a[g]),
      .addr_o    (addr_a[g]),
      .bank_o    (bank_a[g]),
      .cnt_o     (cnt_a[g])
    );
  end

  dma_eng_arb #(.N(N_CH), .IW(IW)) arb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .grant_o(grant),
    .any_o  (any)
  );

  dma_eng_xfer #(
    .N(N_CH), .IW(IW), .AW(AW), .CW(CW), .BW(BW), .PW(PW), .PERI_PAGE(PERI_PAGE)
  ) xfer_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_mask_i(start_mask_i),
    .busy_o      (busy_o),
    .pend_o      (pend),
    .grant_i     (grant),
    .any_i       (any),
    .cur_ch_o    (cur_ch),
    .ctrl_i      (ctrl_a[cur_ch]),
    .pidx_i      (pidx_a[cur_ch]),
    .addr_i      (addr_a[cur_ch]),
    .bank_i      (bank_a[cur_ch]),
    .cnt_i       (cnt_a[cur_ch]),
    .upd_o       (upd),
    .upd_addr_o  (upd_addr),
    .upd_cnt_o   (upd_cnt),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ready_i (bus_ready_i)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o);

endmodule

// File: tb/dma_engine_tb_top.sv
module dma_engine_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [6:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        start_i = 1'b0;
  logic [7:0]  start_mask_i = '0;
  logic        busy_o, bus_req_o, bus_we_o;
  logic [23:0] bus_addr_o;
  logic [7:0]  bus_wdata_o;
  logic [7:0]  bus_rdata_i = '0;
  logic        bus_ready_i = 1'b0;

  always #5 clk_i = ~clk_i;

  dma_engine dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .start_i(start_i), .start_mask_i(start_mask_i),
    .busy_o(busy_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i)
  );

  int unsigned total = 0, fails = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural model state
  int plen [8] = '{1, 2, 2, 4, 4, 4, 2, 4};
  int poff [8][4] = '{'{0,0,0,0}, '{0,1,0,0}, '{0,0,0,0}, '{0,0,1,1},
                      '{0,1,2,3}, '{0,1,0,1}, '{0,0,0,0}, '{0,0,1,1}};
  logic [7:0]  m_ctrl [8];
  logic [7:0]  m_pidx [8];
  logic [7:0]  m_bank [8];
  logic [15:0] m_addr [8];
  logic [15:0] m_cnt  [8];
  logic [24:0] exp_q [$];
  bit          exp_busy = 0;
  bit          fast = 0;
  bit          stall = 0;
  logic [23:0] p_addr;
  logic        p_we;
  logic [7:0]  p_wdata;
  logic [7:0]  last_rd = '0;
  logic [15:0] lfsr = 16'hACE1;
  int unsigned wr_seen = 0;

  function automatic logic [7:0] rd_fn(logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
  endfunction

  task automatic build_queue(logic [7:0] mask);
    for (int c = 0; c < 8; c++) begin
      if (mask[c]) begin
        int n;
        int ptr;
        n = (m_cnt[c] == 16'd0) ? 65536 : int'(m_cnt[c]);
        ptr = 0;
        for (int b = 0; b < n; b++) begin
          logic [23:0] per, mem;
          logic [7:0]  lo;
          lo  = m_pidx[c] + 8'(poff[m_ctrl[c][2:0]][ptr]);
          per = {16'h0021, lo};
          mem = {m_bank[c], m_addr[c]};
          if (m_ctrl[c][7]) begin
            exp_q.push_back({1'b0, per});
            exp_q.push_back({1'b1, mem});
          end else begin
            exp_q.push_back({1'b0, mem});
            exp_q.push_back({1'b1, per});
          end
          if (!m_ctrl[c][3]) m_addr[c] = m_ctrl[c][4] ? m_addr[c] - 16'd1 : m_addr[c] + 16'd1;
          ptr = (ptr + 1) % plen[m_ctrl[c][2:0]];
        end
        m_cnt[c] = '0;
      end
    end
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      bus_ready_i = 1'b0;
      exp_busy = 0;
      stall = 0;
      for (int c = 0; c < 8; c++) begin
        m_ctrl[c] = '0; m_pidx[c] = '0; m_bank[c] = '0; m_addr[c] = '0; m_cnt[c] = '0;
      end
    end else begin
      bit cur_busy;
      cur_busy = exp_busy;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      chk(busy_o == exp_busy, "R9 busy", 32'(busy_o), 32'(exp_busy));
      if (stall)
        chk(bus_req_o && bus_addr_o == p_addr && bus_we_o == p_we && bus_wdata_o == p_wdata,
            "R11 stalled request held", 32'(bus_addr_o), 32'(p_addr));
      bus_ready_i = fast ? 1'b1 : lfsr[0];
      bus_rdata_i = rd_fn(bus_addr_o);
      if (bus_req_o && bus_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected access", 32'(bus_addr_o), 32'hFFFFFFFF);
        end else begin
          logic [24:0] e;
          e = exp_q.pop_front();
          chk({bus_we_o, bus_addr_o} == e, "R3/R4/R5/R6/R8 access", 32'({bus_we_o, bus_addr_o}), 32'(e));
          if (bus_we_o) begin
            chk(bus_wdata_o == last_rd, "R3 write data", 32'(bus_wdata_o), 32'(last_rd));
            wr_seen++;
          end else begin
            last_rd = bus_rdata_i;
          end
          if (exp_q.size() == 0) exp_busy = 0;
        end
      end
      stall   = bus_req_o && !bus_ready_i;
      p_addr  = bus_addr_o;
      p_we    = bus_we_o;
      p_wdata = bus_wdata_o;
      // R10: model ignores config writes and starts while busy
      if (!cur_busy) begin
        if (cfg_we_i) begin
          case (cfg_addr_i[3:0])
            4'd0: m_ctrl[cfg_addr_i[6:4]] = cfg_wdata_i;
            4'd1: m_pidx[cfg_addr_i[6:4]] = cfg_wdata_i;
            4'd2: m_addr[cfg_addr_i[6:4]][7:0] = cfg_wdata_i;
            4'd3: m_addr[cfg_addr_i[6:4]][15:8] = cfg_wdata_i;
            4'd4: m_bank[cfg_addr_i[6:4]] = cfg_wdata_i;
            4'd5: m_cnt[cfg_addr_i[6:4]][7:0] = cfg_wdata_i;
            4'd6: m_cnt[cfg_addr_i[6:4]][15:8] = cfg_wdata_i;
            default: ;
          endcase
        end
        if (start_i && start_mask_i != '0) begin
          build_queue(start_mask_i);
          exp_busy = 1;
        end
      end
    end
  end

  task automatic cfg_wr(int ch, int r, logic [7:0] v);
    @(posedge clk_i); #2;
    cfg_we_i = 1'b1; cfg_addr_i = {3'(ch), 4'(r)}; cfg_wdata_i = v;
    @(posedge clk_i); #2;
    cfg_we_i = 1'b0;
  endtask

  task automatic setup(int ch, logic [7:0] ctrl, logic [7:0] pidx,
                       logic [15:0] ofs, logic [7:0] bank, logic [15:0] cnt);
    cfg_wr(ch, 0, ctrl);
    cfg_wr(ch, 1, pidx);
    cfg_wr(ch, 2, ofs[7:0]);
    cfg_wr(ch, 3, ofs[15:8]);
    cfg_wr(ch, 4, bank);
    cfg_wr(ch, 5, cnt[7:0]);
    cfg_wr(ch, 6, cnt[15:8]);
  endtask

  task automatic go(logic [7:0] mask);
    @(posedge clk_i); #2;
    start_i = 1'b1; start_mask_i = mask;
    @(posedge clk_i); #2;
    start_i = 1'b0;
  endtask

  task automatic finish_run(string tag);
    while (exp_busy) @(posedge clk_i);
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0 && !busy_o, tag, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk_i);
    chk(!busy_o && !bus_req_o, "R1 in reset", 32'({busy_o, bus_req_o}), 32'd0);
    #2 rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !bus_req_o, "R1 after reset", 32'({busy_o, bus_req_o}), 32'd0);

    // R4 R5: quad pattern, count 9 ends one byte into the third pass
    setup(0, 8'h04, 8'h18, 16'h1000, 8'h7E, 16'd9);
    go(8'h01);
    finish_run("R5 quad run done");

    // R2 R5: bit 6 set has no effect, fixed offset, stops mid pattern
    setup(3, 8'h4D, 8'h40, 16'h2345, 8'h01, 16'd3);
    go(8'h08);
    finish_run("R2 fixed alternate run done");

    // R6 R9: offset wrap both ways, index wrap, ascending order
    setup(2, 8'h82, 8'hFF, 16'h0100, 8'h09, 16'd2);
    setup(5, 8'h13, 8'hFE, 16'h0001, 8'h12, 16'd5);
    setup(7, 8'h01, 8'hFF, 16'hFFFE, 8'h34, 16'd4);
    go(8'hA4);
    finish_run("R9 three channel run done");

    // R8: peripheral to memory, single register and decrementing pair pattern
    setup(1, 8'h80, 8'h30, 16'h4000, 8'h20, 16'd3);
    setup(6, 8'h97, 8'h50, 16'h0003, 8'h21, 16'd6);
    go(8'h42);
    finish_run("R8 reverse direction done");

    // R9: zero mask starts nothing
    go(8'h00);
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !bus_req_o, "R9 zero mask", 32'(busy_o), 32'd0);

    // R10: writes and start while busy are ignored
    setup(4, 8'h00, 8'h10, 16'h5000, 8'h44, 16'd20);
    go(8'h10);
    cfg_wr(4, 5, 8'h01);
    cfg_wr(0, 1, 8'h99);
    go(8'h01);
    chk(busy_o, "R10 still busy during writes", 32'(busy_o), 32'd1);
    finish_run("R10 run unaffected");

    // R12: only the count is rewritten; offset and index carry over
    cfg_wr(0, 5, 8'h04);
    cfg_wr(0, 6, 8'h00);
    go(8'h01);
    finish_run("R12 continued run done");

    // R7: zero count moves 65536 bytes
    fast = 1;
    setup(6, 8'h00, 8'h22, 16'h8000, 8'h55, 16'd0);
    wr_seen = 0;
    go(8'h40);
    finish_run("R7 full run done");
    chk(wr_seen == 65536, "R7 byte count", wr_seen, 32'd65536);
    fast = 0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk_i);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule